// File: doc/BRIEF.md
# Hierarchical Block Carry-Lookahead Adder

This block is a purely combinational two-operand binary adder with a carry input. It returns a full-width sum and a carry output. The operands are cut into fixed-size groups of four bits by default. Each group reduces its bits to one group generate term and one group propagate term. A separate lookahead chain turns those pairs, together with the incoming carry, into the carry that enters each group. As a result, no bit-level carry ripple ever crosses from one group into the next.

Inside a group, the sum bits use a short local carry recurrence that starts from the group's incoming carry. A bit propagates a carry when either of its operand bits is set (inclusive OR). The sum bits therefore use a separate exclusive-OR of the operand bits, so the propagate term is never reused as the half-sum.

The total width is a parameter and must be a whole multiple of the group width; a width that breaks this rule stops elaboration. The block is meant to sit inside a larger datapath wherever an unregistered add with carry-in is needed.

Top module: `claAdder`

## Requirements
- R1: `sumOut` equals the low WIDTH bits of the arithmetic sum `opA + opB + carryIn`, for every operand pair and both carry-in values.
- R2: `carryOut` equals bit WIDTH (the bit just above the most significant sum bit) of the full arithmetic sum `opA + opB + carryIn`.
- R3: The carry entering each group equals the carry out of adding only the operand bits below that group, plus `carryIn`. A carry made in the lowest group therefore reaches the top of a run of fully propagating groups in the same evaluation (for example, 0x7FFFFFFF + 1 gives 0x80000000).
- R4: When `opA` XOR `opB` is all ones, every bit propagates. The sum is all ones with `carryOut` = 0 when `carryIn` = 0, and all zeros with `carryOut` = 1 when `carryIn` = 1.
- R5: All ones plus one wraps round: `opA` all ones, `opB` zero and `carryIn` = 1 (or `opB` = 1 and `carryIn` = 0) gives a zero sum and `carryOut` = 1.
- R6: A carry made only at the most significant bit (both operands hold just the top bit) gives a sum equal to `carryIn` and `carryOut` = 1.
- R7: With both operands zero, the sum equals `carryIn` in bit 0 and zero in all other bits, and `carryOut` is 0.
- R8: For fixed operands, raising `carryIn` from 0 to 1 raises the (WIDTH+1)-bit value {`carryOut`, `sumOut`} by exactly one, modulo 2^(WIDTH+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Sum modulo 2^WIDTH |
| carryOut | output | 1 | Carry out of the most significant group |

## Verification
The two carry sources that can meet at one group are the carry sent up by the lookahead chain and the carry the group makes from its own operand bits. Both can also act on the same group in a single evaluation. The bench provokes this with operands whose low group generates while higher groups either generate or only propagate, with `carryIn` set and clear, and with alternating bit patterns. Each result is judged against a 33-bit arithmetic reference computed in the bench, and the R8 check compares each operand pair under both carry-in values.

// File: rtl/claPkg.sv
package claPkg;

  // Summary of one operand group handed from the datapath to the carry chain
  typedef struct packed {
    logic gen;   // group makes a carry on its own
    logic prop;  // group passes an incoming carry through
  } grpPg_t;

endpackage

// File: rtl/claGroupCell.sv
module claGroupCell
  import claPkg::*;
#(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] a,
  input  logic [GROUP_W-1:0] b,
  input  logic               cin,
  output grpPg_t             pg,
  output logic [GROUP_W-1:0] sum
);

  logic [GROUP_W-1:0] bitGen;
  logic [GROUP_W-1:0] bitProp;
  logic [GROUP_W-1:0] halfSum;
  logic [GROUP_W:0]   localCarry;

  assign bitGen  = a & b;
  assign bitProp = a | b;
  assign halfSum = a ^ b;

  // Group terms in nested (factored) form, lowest bit innermost
  always_comb begin
    pg.gen  = bitGen[0];
    pg.prop = bitProp[0];
    for (int i = 1; i < GROUP_W; i++) begin
      pg.gen  = bitGen[i] | (bitProp[i] & pg.gen);
      pg.prop = bitProp[i] & pg.prop;
    end
  end

  // Local carry inside the group, seeded by the chain's carry for this group
  always_comb begin
    localCarry[0] = cin;
    for (int i = 0; i < GROUP_W; i++) begin
      localCarry[i+1] = bitGen[i] | (bitProp[i] & localCarry[i]);
    end
  end

  assign sum = halfSum ^ localCarry[GROUP_W-1:0];

endmodule

// File: rtl/claDatapath.sv
module claDatapath
  import claPkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int GROUP_W = 4,
  localparam int NUM_GRP = WIDTH / GROUP_W
) (
  input  logic [WIDTH-1:0]          opA,
  input  logic [WIDTH-1:0]          opB,
  input  logic [NUM_GRP-1:0]        grpCin,
  output grpPg_t [NUM_GRP-1:0]      pgVec,
  output logic [WIDTH-1:0]          sumOut
);

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGroup
    claGroupCell #(.GROUP_W(GROUP_W)) uCell (
      .a   (opA[g*GROUP_W +: GROUP_W]),
      .b   (opB[g*GROUP_W +: GROUP_W]),
      .cin (grpCin[g]),
      .pg  (pgVec[g]),
      .sum (sumOut[g*GROUP_W +: GROUP_W])
    );
  end

endmodule

// File: rtl/claCarryChain.sv
module claCarryChain
  import claPkg::*;
#(
  parameter int NUM_GRP = 8
) (
  input  grpPg_t [NUM_GRP-1:0] pgVec,
  input  logic                 carryIn,
  output logic [NUM_GRP:0]     grpCarry
);

  // One AND-OR stage per group: carry out = G | (P & carry in)
  always_comb begin
    grpCarry[0] = carryIn;
    for (int k = 0; k < NUM_GRP; k++) begin
      grpCarry[k+1] = pgVec[k].gen | (pgVec[k].prop & grpCarry[k]);
    end
  end

endmodule

// File: rtl/claAdder.sv
module claAdder
  import claPkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int GROUP_W = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  localparam int NUM_GRP = WIDTH / GROUP_W;

  if ((WIDTH % GROUP_W) != 0 || NUM_GRP < 1) begin : gWidthBad
    $error("claAdder: WIDTH must be a positive multiple of GROUP_W");
  end

  grpPg_t [NUM_GRP-1:0] pgVec;
  logic   [NUM_GRP:0]   grpCarry;

  claDatapath #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) uData (
    .opA    (opA),
    .opB    (opB),
    .grpCin (grpCarry[NUM_GRP-1:0]),
    .pgVec  (pgVec),
    .sumOut (sumOut)
  );

  claCarryChain #(.NUM_GRP(NUM_GRP)) uChain (
    .pgVec    (pgVec),
    .carryIn  (carryIn),
    .grpCarry (grpCarry)
  );

  assign carryOut = grpCarry[NUM_GRP];

endmodule

// File: rtl/claAdderChk.sv
module claAdderChk #(
  parameter int WIDTH   = 32,
  parameter int GROUP_W = 4,
  localparam int NUM_GRP = WIDTH / GROUP_W
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut,
  input logic [NUM_GRP:0] grpCarry
);

  logic [WIDTH:0] fullSum;
  logic [WIDTH:0] lowMask;
  logic [WIDTH:0] lowSum;

  assign fullSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    p_sum_r1: assert (sumOut == fullSum[WIDTH-1:0])
      else $error("sum differs from arithmetic sum");
    p_cout_r2: assert (carryOut == fullSum[WIDTH])
      else $error("carry out differs from arithmetic sum");

    lowMask = '0;
    lowSum  = '0;
    for (int k = 1; k < NUM_GRP; k++) begin
      lowMask = ({{WIDTH{1'b0}}, 1'b1} << (k * GROUP_W)) - 1'b1;
      lowSum  = ({1'b0, opA} & lowMask) + ({1'b0, opB} & lowMask)
              + {{WIDTH{1'b0}}, carryIn};
      p_grp_carry_r3: assert (grpCarry[k] == lowSum[k*GROUP_W])
        else $error("carry into group %0d wrong", k);
    end

    if ((opA ^ opB) == {WIDTH{1'b1}}) begin
      p_all_prop_r4: assert (carryOut == carryIn && sumOut == {WIDTH{~carryIn}})
        else $error("all-propagate case wrong");
    end

    if (opA == {WIDTH{1'b1}} && opB == '0 && carryIn) begin
      p_wrap_r5: assert (sumOut == '0 && carryOut)
        else $error("all ones plus one did not wrap");
    end

    if (opA == {1'b1, {(WIDTH-1){1'b0}}} && opB == opA) begin
      p_msb_gen_r6: assert (carryOut && sumOut == WIDTH'(carryIn))
        else $error("top-bit generate wrong");
    end

    if (opA == '0 && opB == '0) begin
      p_zero_r7: assert (!carryOut && sumOut == WIDTH'(carryIn))
        else $error("zero operands wrong");
    end
  end

endmodule

bind claAdder claAdderChk #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) uChk (
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .sumOut   (sumOut),
  .carryOut (carryOut),
  .grpCarry (grpCarry)
);

// File: tb/tb_claAdder.sv
module tb_claAdder;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         c;
    string        tag;
  } vec_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  vec_t vecQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  claAdder #(.WIDTH(W), .GROUP_W(4)) dut (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  function automatic logic [W:0] refAdd(logic [W-1:0] a, logic [W-1:0] b, logic c);
    longint unsigned t;
    t = longint'(a) + longint'(b) + longint'(c);
    return t[W:0];
  endfunction

  task automatic applyVec(vec_t v);
    @(posedge clk);
    #1;
    opA = v.a;
    opB = v.b;
    carryIn = v.c;
    @(negedge clk);
  endtask

  task automatic checkVec(vec_t v);
    logic [W:0] exp;
    applyVec(v);
    exp = refAdd(v.a, v.b, v.c);
    checks++;
    if (sumOut !== exp[W-1:0]) begin
      failures++;
      $display("FAIL %s R1 sum a=%h b=%h c=%0d: got %h expected %h",
               v.tag, v.a, v.b, v.c, sumOut, exp[W-1:0]);
    end
    checks++;
    if (carryOut !== exp[W]) begin
      failures++;
      $display("FAIL %s R2 carry a=%h b=%h c=%0d: got %0d expected %0d",
               v.tag, v.a, v.b, v.c, carryOut, exp[W]);
    end
  endtask

  // R8: same operands, carry-in clear then set, result must step by one
  task automatic pairCheck(logic [W-1:0] a, logic [W-1:0] b);
    vec_t v;
    logic [W:0] r0;
    logic [W:0] r1;
    v.a = a; v.b = b; v.c = 1'b0; v.tag = "R8 cin clear";
    applyVec(v);
    r0 = {carryOut, sumOut};
    v.c = 1'b1;
    applyVec(v);
    r1 = {carryOut, sumOut};
    checks++;
    if (r1 !== r0 + 1'b1) begin
      failures++;
      $display("FAIL R8 a=%h b=%h: got %h expected %h", a, b, r1, r0 + 1'b1);
    end
  endtask

  function automatic vec_t mk(logic [W-1:0] a, logic [W-1:0] b, logic c, string tag);
    vec_t v;
    v.a = a; v.b = b; v.c = c; v.tag = tag;
    return v;
  endfunction

  initial begin
    // reset window: operands held at zero (R7)
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sumOut !== '0 || carryOut !== 1'b0) begin
      failures++;
      $display("FAIL R7 reset state: got %h/%0d expected 0/0", sumOut, carryOut);
    end
    rst = 1'b0;

    vecQ.push_back(mk(32'h0, 32'h0, 1'b0, "R7 zero"));
    vecQ.push_back(mk(32'h0, 32'h0, 1'b1, "R7 zero cin"));
    vecQ.push_back(mk(32'hFFFFFFFF, 32'h0, 1'b1, "R5 ones+cin"));
    vecQ.push_back(mk(32'hFFFFFFFF, 32'h1, 1'b0, "R5 ones+1"));
    vecQ.push_back(mk(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R1 ones+ones"));
    vecQ.push_back(mk(32'hAAAAAAAA, 32'h55555555, 1'b0, "R4 alt prop"));
    vecQ.push_back(mk(32'hAAAAAAAA, 32'h55555555, 1'b1, "R4 alt prop cin"));
    vecQ.push_back(mk(32'hAAAAAAAA, 32'hAAAAAAAA, 1'b1, "R1 alt gen"));
    vecQ.push_back(mk(32'h80000000, 32'h80000000, 1'b0, "R6 msb gen"));
    vecQ.push_back(mk(32'h80000000, 32'h80000000, 1'b1, "R6 msb gen cin"));
    vecQ.push_back(mk(32'h7FFFFFFF, 32'h1, 1'b0, "R3 long carry"));
    vecQ.push_back(mk(32'h0000000F, 32'h1, 1'b0, "R3 one boundary"));
    vecQ.push_back(mk(32'h0FFFFFF0, 32'h0, 1'b1, "R3 no carry"));
    vecQ.push_back(mk(32'hF0F0F0FF, 32'h0F0F0F0F, 1'b1, "R3 mixed gen prop"));
    for (int i = 0; i < 300; i++) begin
      vecQ.push_back(mk($urandom, $urandom, 1'($urandom), "R1 R2 random"));
    end

    while (vecQ.size() > 0) checkVec(vecQ.pop_front());

    pairCheck(32'h0, 32'h0);
    pairCheck(32'hFFFFFFFF, 32'h0);
    pairCheck(32'h12345678, 32'h9ABCDEF0);
    for (int i = 0; i < 20; i++) pairCheck($urandom, $urandom);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule